// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block is the digital output stage of a frequency synthesizer. A single high-speed source clock feeds two independent divider banks. Bank A has one output and bank B has two, and every output is a true/complement pair. Each bank has its own 2-bit ratio select and its own active-high output enable. The two banks use different fixed ratio sets, and odd ratios are produced with a 50% duty cycle.

The source clock reaches the dividers through two cascaded glitch-free clock multiplexers. The first picks between a crystal clock and a single-ended reference clock. The second picks between the synthesizer's VCO clock and that reference path, so the PLL can be bypassed.

An asynchronous master reset stops the multiplexers and clears all dividers, which parks every output at true-low / complement-high. Ratio and enable changes are synchronized into the divider clock and applied only at the boundary between two output periods. This means a bank never produces a truncated pulse.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: With bank A ratio select code 0, 1, 2 or 3, the bank A output period is 1, 2, 3 or 4 source clock periods respectively.
- R2: With bank B ratio select code 0, 1, 2 or 3, both bank B outputs have a period of 2, 4, 5 or 8 source clock periods respectively, and the two bank B outputs are identical.
- R3: For every ratio N, including the odd ratios 3 and 5, the output high time is N/2 source periods, so the duty cycle is 50%.
- R4: While the master reset is high, every true output is low and every complement output is high, asynchronously. After reset is released, both banks resume dividing.
- R5: A bank whose enable is low holds all of its outputs at true low / complement high. Bank B's enable parks both bank B pairs together. Disabling one bank does not change the other bank's output.
- R6: A change of ratio select or enable takes effect only at the end of the current output period, so a high pulse that is already in progress completes with its full length.
- R7: The source select picks the VCO clock when high and the reference path when low. Within the reference path, the crystal select picks the crystal clock when high and the single-ended reference clock when low.
- R8: Switching between clock sources is glitch-free: at most one source gate of each multiplexer is open at any time, and no output pulse is shorter than the shortest legal pulse of the selected ratio.
- R9: Every complement output is always the logical inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Synthesizer VCO clock (modelled as a plain clock) |
| xtal_clk | input | 1 | Crystal oscillator clock |
| ref_clk | input | 1 | Single-ended reference clock |
| pll_on | input | 1 | 1 = VCO clock drives the dividers, 0 = reference path (bypass) |
| xtal_pick | input | 1 | 1 = crystal clock, 0 = single-ended reference, on the reference path |
| mrst | input | 1 | Asynchronous master reset, active high |
| a_ratio_sel | input | 2 | Bank A ratio code (0:÷1, 1:÷2, 2:÷3, 3:÷4) |
| a_oe | input | 1 | Bank A output enable, active high |
| b_ratio_sel | input | 2 | Bank B ratio code (0:÷2, 1:÷4, 2:÷5, 3:÷8) |
| b_oe | input | 1 | Bank B output enable, active high |
| qa | output | 1 | Bank A true output |
| qa_n | output | 1 | Bank A complement output |
| qb | output | B_PAIRS | Bank B true outputs |
| qb_n | output | B_PAIRS | Bank B complement outputs |

## Verification
The hardest situation to create is a configuration change that lands in the middle of a high pulse. If such a change took effect early, it would truncate the pulse. The stimulus waits for a rising output edge, moves the ratio select or drops the enable a few nanoseconds later, and then times the falling edge to show that the old pulse kept its full width. Source switching is covered by timing output edges while the bypass and crystal selects are flipped, and a pulse-width monitor records the narrowest pulse seen during those switches.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned NCODES = 1 << CODE_W;
  localparam int unsigned RW     = 4;

  typedef logic [CODE_W-1:0]            code_t;
  typedef logic [RW-1:0]                ratio_t;
  typedef logic [NCODES-1:0][RW-1:0]    ratio_tbl_t;

  // Entry k holds the ratio for select code k.
  localparam ratio_tbl_t BANK_A_RATIOS = {4'd4, 4'd3, 4'd2, 4'd1};
  localparam ratio_tbl_t BANK_B_RATIOS = {4'd8, 4'd5, 4'd4, 4'd2};

  function automatic ratio_t ratio_of(input ratio_tbl_t tbl, input code_t c);
    return tbl[c];
  endfunction

  function automatic ratio_t last_count(input ratio_t n);
    return n - 1'b1;
  endfunction

  // Posedge-phase high length: ceil(N/2) cycles; odd ratios trim half a cycle later.
  function automatic ratio_t high_len(input ratio_t n);
    logic [RW:0] s;
    s = {1'b0, n} + 1'b1;
    return s[RW:1];
  endfunction

  function automatic logic is_unit(input ratio_t n);
    return n == ratio_t'(1);
  endfunction
endpackage

// File: rtl/glitchless_clk_mux.sv
`timescale 1ns/1ps
module glitchless_clk_mux (
  input  logic clk0,
  input  logic clk1,
  input  logic sel,
  input  logic rst,
  output logic clk_out
);
  logic arm0, arm1, gate0, gate1;

  // Each side arms on its rising edge only once the other gate is closed,
  // then opens its gate on its falling edge, while its clock is low.
  always_ff @(posedge clk1 or posedge rst)
    if (rst) arm1 <= 1'b0;
    else     arm1 <= sel & ~gate0;

  always_ff @(negedge clk1 or posedge rst)
    if (rst) gate1 <= 1'b0;
    else     gate1 <= arm1;

  always_ff @(posedge clk0 or posedge rst)
    if (rst) arm0 <= 1'b0;
    else     arm0 <= ~sel & ~gate1;

  always_ff @(negedge clk0 or posedge rst)
    if (rst) gate0 <= 1'b0;
    else     gate0 <= arm0;

  assign clk_out = (clk0 & gate0) | (clk1 & gate1);

  a_r8_single_gate_c0: assert property (@(posedge clk0) disable iff (rst) !(gate0 && gate1));
  a_r8_single_gate_c1: assert property (@(posedge clk1) disable iff (rst) !(gate0 && gate1));
endmodule

// File: rtl/bank_divider.sv
`timescale 1ns/1ps
module bank_divider
  import clkdiv_pkg::*;
#(
  parameter ratio_tbl_t RATIOS = BANK_A_RATIOS
) (
  input  logic  clk,
  input  logic  rst,
  input  code_t sel_in,
  input  logic  oe_in,
  output logic  div_out
);
  code_t  sel_m, sel_s, cur, cur_nx;
  logic   oe_m, oe_s, on, on_nx;
  ratio_t cnt, cnt_nx, cur_n, nx_n;
  logic   wrap, p_nx, p_ph, n_ph;

  // Two-flop capture of the quasi-static controls in the divider clock.
  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sel_m <= '0; sel_s <= '0; oe_m <= 1'b0; oe_s <= 1'b0;
    end else begin
      sel_m <= sel_in; sel_s <= sel_m; oe_m <= oe_in; oe_s <= oe_m;
    end

  // Period boundary: new ratio and enable are adopted only here.
  assign cur_n  = ratio_of(RATIOS, cur);
  assign wrap   = (cnt == last_count(cur_n));
  assign cur_nx = wrap ? sel_s : cur;
  assign on_nx  = wrap ? oe_s  : on;
  assign cnt_nx = wrap ? '0 : cnt + 1'b1;
  assign nx_n   = ratio_of(RATIOS, cur_nx);
  assign p_nx   = on_nx && (cnt_nx < high_len(nx_n));

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      cnt <= '0; cur <= '0; on <= 1'b0; p_ph <= 1'b0;
    end else begin
      cnt <= cnt_nx; cur <= cur_nx; on <= on_nx; p_ph <= p_nx;
    end

  // Half-cycle delayed copy for odd ratios and for the divide-by-one gate.
  always_ff @(negedge clk or posedge rst)
    if (rst) n_ph <= 1'b0;
    else     n_ph <= p_ph;

  always_comb begin
    if (is_unit(cur_n))  div_out = clk & n_ph;
    else if (cur_n[0])   div_out = p_ph & n_ph;
    else                 div_out = p_ph;
  end

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_count(cur_n));
  a_r6_cfg_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur) |-> (cnt == '0));
  a_r5_parked_when_off: assert property (@(negedge clk) disable iff (rst)
    (!on && $past(!on)) |-> !div_out);
endmodule

// File: rtl/dual_bank_clkdiv.sv
`timescale 1ns/1ps
module dual_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int unsigned B_PAIRS = 2
) (
  input  logic               vco_clk,
  input  logic               xtal_clk,
  input  logic               ref_clk,
  input  logic               pll_on,
  input  logic               xtal_pick,
  input  logic               mrst,
  input  logic [CODE_W-1:0]  a_ratio_sel,
  input  logic               a_oe,
  input  logic [CODE_W-1:0]  b_ratio_sel,
  input  logic               b_oe,
  output logic               qa,
  output logic               qa_n,
  output logic [B_PAIRS-1:0] qb,
  output logic [B_PAIRS-1:0] qb_n
);
  logic refpath_clk, div_clk, a_out, b_out;

  glitchless_clk_mux u_ref_mux (
    .clk0(ref_clk), .clk1(xtal_clk), .sel(xtal_pick), .rst(mrst), .clk_out(refpath_clk)
  );

  glitchless_clk_mux u_src_mux (
    .clk0(refpath_clk), .clk1(vco_clk), .sel(pll_on), .rst(mrst), .clk_out(div_clk)
  );

  bank_divider #(.RATIOS(BANK_A_RATIOS)) u_bank_a (
    .clk(div_clk), .rst(mrst), .sel_in(a_ratio_sel), .oe_in(a_oe), .div_out(a_out)
  );

  bank_divider #(.RATIOS(BANK_B_RATIOS)) u_bank_b (
    .clk(div_clk), .rst(mrst), .sel_in(b_ratio_sel), .oe_in(b_oe), .div_out(b_out)
  );

  assign qa   = a_out;
  assign qa_n = ~a_out;

  for (genvar i = 0; i < B_PAIRS; i++) begin : g_bpair
    assign qb[i]   = b_out;
    assign qb_n[i] = ~b_out;
  end

  a_r4_reset_parks: assert property (@(posedge vco_clk)
    mrst |-> (!qa && qa_n && (qb == '0) && (qb_n == '1)));
endmodule

// File: tb/tb_dual_bank_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_bank_clkdiv;
  logic vco_clk = 1'b0, xtal_clk = 1'b0, ref_clk = 1'b0;
  logic pll_on, xtal_pick, mrst, a_oe, b_oe;
  logic [1:0] a_ratio_sel, b_ratio_sel;
  logic qa, qa_n;
  logic [1:0] qb, qb_n;

  int n_chk = 0, n_bad = 0;

  dual_bank_clkdiv dut (
    .vco_clk(vco_clk), .xtal_clk(xtal_clk), .ref_clk(ref_clk),
    .pll_on(pll_on), .xtal_pick(xtal_pick), .mrst(mrst),
    .a_ratio_sel(a_ratio_sel), .a_oe(a_oe), .b_ratio_sel(b_ratio_sel), .b_oe(b_oe),
    .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n)
  );

  always #5  vco_clk  = ~vco_clk;   // 100 MHz
  always #13 xtal_clk = ~xtal_clk;  // 26 ns
  always #17 ref_clk  = ~ref_clk;   // 34 ns

  typedef struct packed {
    logic       bank;   // 0 = A, 1 = B
    logic [1:0] code;
    int         per;    // expected period (ns)
    int         hi;     // expected high time (ns)
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd0, 10, 5},  '{1'b0, 2'd1, 20, 10},
    '{1'b0, 2'd2, 30, 15}, '{1'b0, 2'd3, 40, 20},
    '{1'b1, 2'd0, 20, 10}, '{1'b1, 2'd1, 40, 20},
    '{1'b1, 2'd2, 50, 25}, '{1'b1, 2'd3, 80, 40}
  };

  // Pulse-width monitor for source switching (R8)
  bit  mon = 1'b0;
  time last_t = 0;
  int  min_w = 1000;
  always @(qa) begin
    if (mon && int'($time - last_t) < min_w) min_w = int'($time - last_t);
    last_t = $time;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_edge(input int w, input bit rise);
    case (w)
      0: if (rise) @(posedge qa);    else @(negedge qa);
      1: if (rise) @(posedge qb[0]); else @(negedge qb[0]);
      default: if (rise) @(posedge qb[1]); else @(negedge qb[1]);
    endcase
  endtask

  task automatic measure(input int w, output int per, output int hi);
    time t0, t1, t2;
    wait_edge(w, 1'b1); t0 = $time;
    wait_edge(w, 1'b0); t1 = $time;
    wait_edge(w, 1'b1); t2 = $time;
    per = int'(t2 - t0);
    hi  = int'(t1 - t0);
  endtask

  task automatic check_parked(input bit bank_b, input string req);
    int bad = 0;
    @(posedge vco_clk); #2;
    for (int i = 0; i < 30; i++) begin
      if (!bank_b && (qa !== 1'b0 || qa_n !== 1'b1)) bad++;
      if (bank_b && (qb !== 2'b00 || qb_n !== 2'b11)) bad++;
      #10;
    end
    chk(bad == 0, req, bank_b ? "bank B parked samples bad" : "bank A parked samples bad", bad, 0);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int per, hi, bad;
    time t0;
    mrst = 1'b1; pll_on = 1'b1; xtal_pick = 1'b1;
    a_ratio_sel = 2'd3; b_ratio_sel = 2'd3; a_oe = 1'b1; b_oe = 1'b1;
    #23;
    // R4: reset state
    chk(qa === 1'b0 && qa_n === 1'b1 && qb === 2'b00 && qb_n === 2'b11,
        "R4", "reset outputs {qa,qa_n,qb,qb_n}", {qa, qa_n, qb, qb_n}, 6'b010011);
    #17 mrst = 1'b0;
    #400;

    // Ratio table walk: R1 (bank A), R2 (bank B), R3 (duty on all, odd ones included)
    foreach (VECS[k]) begin
      if (!VECS[k].bank) a_ratio_sel = VECS[k].code;
      else               b_ratio_sel = VECS[k].code;
      #300;
      if (!VECS[k].bank) begin
        measure(0, per, hi);
        chk(per == VECS[k].per, "R1", "bank A period", per, VECS[k].per);
        chk(hi == VECS[k].hi, "R3", "bank A high time", hi, VECS[k].hi);
      end else begin
        for (int w = 1; w < 3; w++) begin
          measure(w, per, hi);
          chk(per == VECS[k].per, "R2", "bank B period", per, VECS[k].per);
          chk(hi == VECS[k].hi, "R3", "bank B high time", hi, VECS[k].hi);
        end
      end
    end

    // R9: complement outputs
    bad = 0;
    @(posedge vco_clk); #2;
    for (int i = 0; i < 40; i++) begin
      if (qa_n !== ~qa || qb_n !== ~qb) bad++;
      #10;
    end
    chk(bad == 0, "R9", "complement mismatches", bad, 0);

    // R6/R5: disable bank A mid-pulse, pulse completes, then parks; B unaffected
    a_ratio_sel = 2'd3; b_ratio_sel = 2'd1;
    #300;
    @(posedge qa); t0 = $time; #3 a_oe = 1'b0;
    @(negedge qa);
    chk(int'($time - t0) == 20, "R6", "last pulse before disable", int'($time - t0), 20);
    #100;
    check_parked(1'b0, "R5");
    measure(1, per, hi);
    chk(per == 40, "R5", "bank B period while A disabled", per, 40);

    // R6: re-enable gives a full first pulse
    a_oe = 1'b1;
    @(posedge qa); t0 = $time;
    @(negedge qa);
    chk(int'($time - t0) == 20, "R6", "first pulse after enable", int'($time - t0), 20);

    // R5: bank B disable parks both pairs; A keeps running
    b_oe = 1'b0;
    #200;
    check_parked(1'b1, "R5");
    measure(0, per, hi);
    chk(per == 40, "R5", "bank A period while B disabled", per, 40);
    b_oe = 1'b1;

    // R6: ratio change mid-pulse (div4 -> div3)
    #200;
    @(posedge qa); t0 = $time; #3 a_ratio_sel = 2'd2;
    @(negedge qa);
    chk(int'($time - t0) == 20, "R6", "pulse during ratio change", int'($time - t0), 20);
    measure(0, per, hi);
    chk(per == 30, "R6", "period after ratio change", per, 30);
    chk(hi == 15, "R6", "high time after ratio change", hi, 15);

    // R7/R8: source selection with pulse-width monitor
    a_ratio_sel = 2'd1;
    #300;
    min_w = 1000; mon = 1'b1;
    pll_on = 1'b0; xtal_pick = 1'b1;
    #1500;
    measure(0, per, hi);
    chk(per == 52, "R7", "bank A div2 period from crystal", per, 52);
    xtal_pick = 1'b0;
    #1500;
    measure(0, per, hi);
    chk(per == 68, "R7", "bank A div2 period from reference", per, 68);
    pll_on = 1'b1;
    #1500;
    measure(0, per, hi);
    chk(per == 20, "R7", "bank A div2 period back on VCO", per, 20);
    mon = 1'b0;
    chk(min_w >= 10, "R8", "narrowest pulse during source switches", min_w, 10);

    // R4: reset in mid-run parks asynchronously, then outputs resume
    @(posedge vco_clk); #2 mrst = 1'b1;
    #1;
    chk(qa === 1'b0 && qa_n === 1'b1 && qb === 2'b00 && qb_n === 2'b11,
        "R4", "mid-run reset outputs {qa,qa_n,qb,qb_n}", {qa, qa_n, qb, qb_n}, 6'b010011);
    #50 mrst = 1'b0;
    #300;
    measure(0, per, hi);
    chk(per == 20, "R4", "bank A period after reset release", per, 20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule